// File: doc/BRIEF.md
# Data Watchpoint Address Matcher

This block holds a small set of watchpoint entries. Each entry is a value register and a control register. Every data access the core presents is compared against all entries at once. An access carries an address, a size of 1, 2, 4 or 8 bytes, a read/write flag and an unprivileged-instruction flag. The block reports a hit one clock after the access is presented, so the core can stop the access before it completes.

Each entry turns its control fields into a watched byte range. There are two ways to do this:

- **Byte-select mode.** The first contiguous run of ones in an 8-bit byte-select field picks the bytes, counted from an 8-aligned base. When value bit 2 is set, the base is 4-aligned and only the low four select bits count.
- **Mask mode.** A power-of-two mask picks an aligned region of up to 2 GB.

Reserved encodings disable their entry. Each entry can also be filtered in three ways: by access type, by a per-level enable, and by a link to one of the externally computed breakpoint context comparator results. Two global gates suppress every hit. On a hit the block returns:

- the lowest matching entry index,
- the access address as the fault address,
- a write-not-read flag for the syndrome.

Top module: `wp_matcher`

## Requirements
- R1: During and after reset all outputs are zero and every entry is disabled, so no access hits until an entry is configured.
- R2: Control bit 0 enables the entry. The access-type field in control bits [2:1] behaves as follows: 01 matches reads only, 10 matches writes only, 11 matches both, and 00 disables the entry.
- R3: With mask field zero and value bit 2 clear, the watched range starts at the value address with bits [2:0] cleared. The range is offset by the number of trailing zeros of the byte-select field (control bits [10:3]). Its length is the run of consecutive ones from that point, and any later ones are ignored. An all-zero select field disables the entry.
- R4: With mask field zero and value bit 2 set, the base is the value address with bits [1:0] cleared, and only select bits [3:0] are used.
- R5: A mask field (control bits [15:11]) of 3 to 31 watches the aligned 2^mask-byte region that contains the value address. The byte-select field and the value's low bits below the mask are ignored.
- R6: Mask values 1 and 2 are reserved and disable the entry.
- R7: An access hits when any of its bytes (address up to address+size-1, with size code 0..3 meaning 1, 2, 4 or 8 bytes) lies inside the watched range.
- R8: Control bits [23:20] enable the entry per privilege level (bit L for level L). An access with the unprivileged flag set is checked as level 0.
- R9: No hit is reported while either the monitor watch enable or the debug exception enable is low.
- R10: When link bit 16 is set, a hit also requires ctx_match at the index in control bits [19:17]. An index at or beyond the number of context inputs never matches.
- R11: When several entries match, the lowest index is reported.
- R12: The outputs for an access appear on the clock edge that follows it. On a hit: wp_hit is high, wp_fault_addr equals the access address, and wp_wnr equals the write flag. Without a hit, all four outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctl | input | 1 | 1 writes the control register, 0 writes the value register |
| cfg_idx | input | IDXW | Entry written |
| cfg_wdata | input | AW | Write data (control uses bits [23:0]) |
| mon_watch_en | input | 1 | Global watchpoint enable |
| dbg_exc_en | input | 1 | Debug exceptions currently allowed |
| cur_level | input | 2 | Current privilege level |
| ctx_match | input | NCTX | Results of the breakpoint context comparators |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | AW | Access byte address |
| acc_size | input | 2 | Log2 of access size in bytes |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_unpriv | input | 1 | Access comes from an unprivileged load/store instruction |
| wp_hit | output | 1 | Watchpoint hit |
| wp_idx | output | IDXW | Index of reporting entry |
| wp_fault_addr | output | AW | Fault address |
| wp_wnr | output | 1 | Write-not-read for the syndrome |

## Verification
A corrupted entry register shows up at the ports in one of two ways. Either a range boundary moves, or a hit appears or vanishes on the very next access to that region, one cycle after it is presented. An error in the run decoder is caught by probing bytes just inside and just outside each range: a wrong start offset or a wrong run length moves the first or last watched byte. Errors in the priority logic or the output registers show up as a wrong index, a wrong fault address or a wrong write flag in the cycle after the access, and never later.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

  localparam int CTLW = 24;

  // Control layout, MSB first: level enables, link index, link, mask,
  // byte select, access type, enable.
  typedef struct packed {
    logic [3:0] lvl;
    logic [2:0] lidx;
    logic       link;
    logic [4:0] mask;
    logic [7:0] bsel;
    logic [1:0] acc;
    logic       en;
  } wp_ctl_t;

  // Returns {length[3:0], start[2:0]} of the first run of ones.
  function automatic logic [6:0] first_run(input logic [7:0] bs);
    logic [2:0] start;
    logic [3:0] len;
    logic       found;
    logic       stop;
    start = 3'd0;
    found = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!found && bs[i]) begin
        start = 3'(i);
        found = 1'b1;
      end
    end
    len  = 4'd0;
    stop = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i >= int'(start) && !stop) begin
        if (bs[i]) len = len + 4'd1;
        else       stop = 1'b1;
      end
    end
    return {len, start};
  endfunction

endpackage

// File: rtl/wpm_range.sv
module wpm_range
  import wpm_pkg::*;
#(
  parameter int AW = 32
) (
  input  wp_ctl_t       ctl,
  input  logic [AW-1:0] val,
  output logic          rng_ok,
  output logic [AW:0]   lo,
  output logic [AW:0]   hi
);

  logic [AW:0] span;
  logic [AW:0] base;
  logic [7:0]  bs;
  logic [6:0]  run;

  always_comb begin
    rng_ok = 1'b0;
    span   = '0;
    base   = '0;
    bs     = '0;
    run    = '0;
    lo     = '0;
    hi     = '0;
    if (ctl.mask != 5'd0) begin
      span   = (AW+1)'(1) << ctl.mask;
      lo     = {1'b0, val} & ~(span - (AW+1)'(1));
      hi     = lo + span;
      rng_ok = ctl.en && (ctl.acc != 2'b00) && (ctl.mask >= 5'd3);
    end else begin
      if (val[2]) begin
        bs   = {4'b0000, ctl.bsel[3:0]};
        base = {1'b0, val[AW-1:2], 2'b00};
      end else begin
        bs   = ctl.bsel;
        base = {1'b0, val[AW-1:3], 3'b000};
      end
      run    = first_run(bs);
      lo     = base + (AW+1)'(run[2:0]);
      hi     = lo + (AW+1)'(run[6:3]);
      rng_ok = ctl.en && (ctl.acc != 2'b00) && (bs != 8'd0);
    end
  end

endmodule

// File: rtl/wpm_cmp.sv
module wpm_cmp
  import wpm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NCTX = 4
) (
  input  wp_ctl_t         ctl,
  input  logic            rng_ok,
  input  logic [AW:0]     lo,
  input  logic [AW:0]     hi,
  input  logic [AW-1:0]   acc_addr,
  input  logic [1:0]      acc_size,
  input  logic            acc_write,
  input  logic [1:0]      eff_lvl,
  input  logic [NCTX-1:0] ctx_match,
  output logic            match
);

  logic [AW:0] acc_lo;
  logic [AW:0] acc_hi;
  logic [7:0]  ctx_pad;
  logic        type_ok;
  logic        lvl_ok;
  logic        link_ok;

  always_comb begin
    acc_lo  = {1'b0, acc_addr};
    acc_hi  = acc_lo + ((AW+1)'(1) << acc_size);
    ctx_pad = 8'(ctx_match);
    type_ok = acc_write ? ctl.acc[1] : ctl.acc[0];
    lvl_ok  = ctl.lvl[eff_lvl];
    link_ok = !ctl.link || ctx_pad[ctl.lidx];
    match   = rng_ok && type_ok && lvl_ok && link_ok &&
              (acc_lo < hi) && (lo < acc_hi);
  end

endmodule

// File: rtl/wp_matcher.sv
module wp_matcher
  import wpm_pkg::*;
#(
  parameter int N    = 4,
  parameter int AW   = 32,
  parameter int NCTX = 4,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_ctl,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            mon_watch_en,
  input  logic            dbg_exc_en,
  input  logic [1:0]      cur_level,
  input  logic [NCTX-1:0] ctx_match,
  input  logic            acc_valid,
  input  logic [AW-1:0]   acc_addr,
  input  logic [1:0]      acc_size,
  input  logic            acc_write,
  input  logic            acc_unpriv,
  output logic            wp_hit,
  output logic [IDXW-1:0] wp_idx,
  output logic [AW-1:0]   wp_fault_addr,
  output logic            wp_wnr
);

  logic [AW-1:0]   val_q [N];
  logic [AW-1:0]   val_d [N];
  wp_ctl_t         ctl_q [N];
  wp_ctl_t         ctl_d [N];
  logic [N-1:0]    match;
  logic [1:0]      eff_lvl;
  logic            sel_hit;
  logic [IDXW-1:0] sel_idx;
  logic            fire;
  logic            hit_d;
  logic [IDXW-1:0] idx_d;
  logic [AW-1:0]   addr_d;
  logic            wnr_d;
  logic            unused_cfg_hi;

  assign unused_cfg_hi = ^cfg_wdata[AW-1:CTLW];

  // Configuration next state
  always_comb begin
    for (int i = 0; i < N; i++) begin
      val_d[i] = val_q[i];
      ctl_d[i] = ctl_q[i];
      if (cfg_we && (cfg_idx == IDXW'(i))) begin
        if (cfg_ctl) ctl_d[i] = wp_ctl_t'(cfg_wdata[CTLW-1:0]);
        else         val_d[i] = cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        val_q[i] <= '0;
        ctl_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        val_q[i] <= val_d[i];
        ctl_q[i] <= ctl_d[i];
      end
    end
  end

  // Unprivileged load/store instructions are checked as level 0
  assign eff_lvl = acc_unpriv ? 2'd0 : cur_level;

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic        rng_ok;
    logic [AW:0] lo;
    logic [AW:0] hi;

    wpm_range #(.AW(AW)) u_range (
      .ctl    (ctl_q[g]),
      .val    (val_q[g]),
      .rng_ok (rng_ok),
      .lo     (lo),
      .hi     (hi)
    );

    wpm_cmp #(.AW(AW), .NCTX(NCTX)) u_cmp (
      .ctl       (ctl_q[g]),
      .rng_ok    (rng_ok),
      .lo        (lo),
      .hi        (hi),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .acc_write (acc_write),
      .eff_lvl   (eff_lvl),
      .ctx_match (ctx_match),
      .match     (match[g])
    );
  end

  // Lowest index wins
  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_hit = 1'b1;
        sel_idx = IDXW'(i);
      end
    end
  end

  always_comb begin
    fire   = acc_valid && mon_watch_en && dbg_exc_en && sel_hit;
    hit_d  = fire;
    idx_d  = fire ? sel_idx : '0;
    addr_d = fire ? acc_addr : '0;
    wnr_d  = fire && acc_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_hit        <= 1'b0;
      wp_idx        <= '0;
      wp_fault_addr <= '0;
      wp_wnr        <= 1'b0;
    end else begin
      wp_hit        <= hit_d;
      wp_idx        <= idx_d;
      wp_fault_addr <= addr_d;
      wp_wnr        <= wnr_d;
    end
  end

endmodule

// File: rtl/wpm_chk.sv
module wpm_chk #(
  parameter int N    = 4,
  parameter int AW   = 32,
  parameter int NCTX = 4,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            cfg_ctl,
  input logic [IDXW-1:0] cfg_idx,
  input logic [AW-1:0]   cfg_wdata,
  input logic            mon_watch_en,
  input logic            dbg_exc_en,
  input logic [1:0]      cur_level,
  input logic [NCTX-1:0] ctx_match,
  input logic            acc_valid,
  input logic [AW-1:0]   acc_addr,
  input logic [1:0]      acc_size,
  input logic            acc_write,
  input logic            acc_unpriv,
  input logic            wp_hit,
  input logic [IDXW-1:0] wp_idx,
  input logic [AW-1:0]   wp_fault_addr,
  input logic            wp_wnr
);

  // R12: a hit always follows a presented access
  p_hit_after_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> $past(acc_valid));

  // R9: both global gates were open for the access that hit
  p_gates_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> $past(mon_watch_en && dbg_exc_en));

  // R12: fault address is the access address
  p_fault_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> (wp_fault_addr == $past(acc_addr)));

  // R12: write-not-read follows the access direction
  p_wnr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> (wp_wnr == $past(acc_write)));

  // R12: quiet outputs without a hit
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_hit |-> (wp_fault_addr == '0 && !wp_wnr && wp_idx == '0));

  // R1: outputs are zero while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!wp_hit && wp_fault_addr == '0);
    end
  end

endmodule

bind wp_matcher wpm_chk #(.N(N), .AW(AW), .NCTX(NCTX)) u_chk (.*);

// File: tb/wp_matcher_test.sv
module wp_matcher_test;

  localparam int N    = 4;
  localparam int AW   = 32;
  localparam int NCTX = 4;
  localparam int IDXW = 2;

  logic            clk;
  logic            rst_n;
  logic            cfg_we;
  logic            cfg_ctl;
  logic [IDXW-1:0] cfg_idx;
  logic [AW-1:0]   cfg_wdata;
  logic            mon_watch_en;
  logic            dbg_exc_en;
  logic [1:0]      cur_level;
  logic [NCTX-1:0] ctx_match;
  logic            acc_valid;
  logic [AW-1:0]   acc_addr;
  logic [1:0]      acc_size;
  logic            acc_write;
  logic            acc_unpriv;
  logic            wp_hit;
  logic [IDXW-1:0] wp_idx;
  logic [AW-1:0]   wp_fault_addr;
  logic            wp_wnr;

  int n_chk  = 0;
  int n_fail = 0;

  wp_matcher #(.N(N), .AW(AW), .NCTX(NCTX)) uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  sz;
    logic        wr;
    logic        up;
    logic [1:0]  lvl;
    logic [3:0]  ctx;
    logic        hit;
    logic [1:0]  idx;
  } vec_t;

  // Entry 0: reads, select 0x0C at 0x1000 -> bytes 0x1002..0x1003, level 0 only
  // Entry 1: writes, mask 12 at 0x23456 -> 0x23000..0x23FFF
  // Entry 2: both, value bit 2 set, select 0x06 at 0x2004 -> 0x2005..0x2006
  // Entry 3: both, select 0xB1 at 0x3000 -> 0x3000 only, linked to ctx 2
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{32'h1002, 2'd0, 1'b0, 1'b0, 2'd0, 4'h0, 1'b1, 2'd0}, // R3 start byte
    '{32'h1000, 2'd1, 1'b0, 1'b0, 2'd0, 4'h0, 1'b0, 2'd0}, // R3 below range
    '{32'h1000, 2'd2, 1'b0, 1'b0, 2'd0, 4'h0, 1'b1, 2'd0}, // R7 word overlaps
    '{32'h1004, 2'd0, 1'b0, 1'b0, 2'd0, 4'h0, 1'b0, 2'd0}, // R3 past run end
    '{32'h1002, 2'd0, 1'b1, 1'b0, 2'd0, 4'h0, 1'b0, 2'd0}, // R2 read-only entry
    '{32'h1003, 2'd0, 1'b0, 1'b0, 2'd1, 4'h0, 1'b0, 2'd0}, // R8 level 1 off
    '{32'h1003, 2'd0, 1'b0, 1'b1, 2'd1, 4'h0, 1'b1, 2'd0}, // R8 unpriv as L0
    '{32'h1002, 2'd0, 1'b0, 1'b1, 2'd3, 4'h0, 1'b1, 2'd0}, // R8 unpriv from L3
    '{32'h23FF8, 2'd3, 1'b1, 1'b0, 2'd2, 4'h0, 1'b1, 2'd1}, // R5 top of region
    '{32'h24000, 2'd0, 1'b1, 1'b0, 2'd2, 4'h0, 1'b0, 2'd0}, // R5 above region
    '{32'h23000, 2'd0, 1'b0, 1'b0, 2'd2, 4'h0, 1'b0, 2'd0}, // R2 write-only entry
    '{32'h22FFF, 2'd1, 1'b1, 1'b0, 2'd2, 4'h0, 1'b1, 2'd1}, // R7 straddle low edge
    '{32'h2004, 2'd0, 1'b0, 1'b0, 2'd1, 4'h0, 1'b0, 2'd0}, // R4 byte before
    '{32'h2005, 2'd0, 1'b0, 1'b0, 2'd1, 4'h0, 1'b1, 2'd2}, // R4 first byte
    '{32'h2006, 2'd0, 1'b1, 1'b0, 2'd1, 4'h0, 1'b1, 2'd2}, // R4 last byte, write
    '{32'h2007, 2'd0, 1'b0, 1'b0, 2'd1, 4'h0, 1'b0, 2'd0}, // R4 byte after
    '{32'h2004, 2'd1, 1'b0, 1'b0, 2'd1, 4'h0, 1'b1, 2'd2}, // R7 halfword overlap
    '{32'h3000, 2'd0, 1'b0, 1'b0, 2'd1, 4'h4, 1'b1, 2'd3}, // R10 link satisfied
    '{32'h3000, 2'd0, 1'b0, 1'b0, 2'd1, 4'hB, 1'b0, 2'd0}, // R10 link missing
    '{32'h3004, 2'd0, 1'b0, 1'b0, 2'd1, 4'h4, 1'b0, 2'd0}  // R3 later ones ignored
  };

  function automatic logic [31:0] mk_ctl(input logic en, input logic [1:0] acc,
      input logic [7:0] bsel, input logic [4:0] mask, input logic link,
      input logic [2:0] lidx, input logic [3:0] lvl);
    return {8'h00, lvl, lidx, link, mask, bsel, acc, en};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic is_ctl, input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_ctl   = is_ctl;
    cfg_idx   = IDXW'(idx);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Presents one access; returns with the registered result visible
  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
      input logic up, input logic [1:0] lvl, input logic [3:0] ctx);
    @(negedge clk);
    acc_valid  = 1'b1;
    acc_addr   = a;
    acc_size   = sz;
    acc_write  = wr;
    acc_unpriv = up;
    cur_level  = lvl;
    ctx_match  = ctx;
    @(negedge clk);
    acc_valid  = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] a, input logic wr,
      input logic [1:0] idx);
    check(req, {63'd0, wp_hit}, 64'd1);
    check(req, {62'd0, wp_idx}, {62'd0, idx});
    check(req, {32'd0, wp_fault_addr}, {32'd0, a});
    check(req, {63'd0, wp_wnr}, {63'd0, wr});
  endtask

  task automatic expect_miss(input string req);
    check(req, {63'd0, wp_hit}, 64'd0);
    check(req, {32'd0, wp_fault_addr}, 64'd0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    cfg_we       = 1'b0;
    cfg_ctl      = 1'b0;
    cfg_idx      = '0;
    cfg_wdata    = '0;
    mon_watch_en = 1'b1;
    dbg_exc_en   = 1'b1;
    cur_level    = 2'd0;
    ctx_match    = '0;
    acc_valid    = 1'b0;
    acc_addr     = '0;
    acc_size     = '0;
    acc_write    = 1'b0;
    acc_unpriv   = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    check("R1", {63'd0, wp_hit}, 64'd0);
    check("R1", {32'd0, wp_fault_addr}, 64'd0);
    rst_n = 1'b1;
    // R1: nothing configured, nothing hits
    access(32'h0000_0000, 2'd3, 1'b0, 1'b0, 2'd0, 4'hF);
    expect_miss("R1");

    cfg(0, 1'b0, 32'h0000_1000);
    cfg(0, 1'b1, mk_ctl(1'b1, 2'b01, 8'h0C, 5'd0, 1'b0, 3'd0, 4'b0001));
    cfg(1, 1'b0, 32'h0002_3456);
    cfg(1, 1'b1, mk_ctl(1'b1, 2'b10, 8'h00, 5'd12, 1'b0, 3'd0, 4'hF));
    cfg(2, 1'b0, 32'h0000_2004);
    cfg(2, 1'b1, mk_ctl(1'b1, 2'b11, 8'h06, 5'd0, 1'b0, 3'd0, 4'hF));
    cfg(3, 1'b0, 32'h0000_3000);
    cfg(3, 1'b1, mk_ctl(1'b1, 2'b11, 8'hB1, 5'd0, 1'b1, 3'd2, 4'hF));

    for (int v = 0; v < NV; v++) begin
      access(VECS[v].addr, VECS[v].sz, VECS[v].wr, VECS[v].up, VECS[v].lvl, VECS[v].ctx);
      if (VECS[v].hit) expect_hit($sformatf("vector %0d", v), VECS[v].addr, VECS[v].wr, VECS[v].idx);
      else             expect_miss($sformatf("vector %0d", v));
    end

    // R9: global gates
    mon_watch_en = 1'b0;
    access(32'h1002, 2'd0, 1'b0, 1'b0, 2'd0, 4'h0);
    expect_miss("R9 monitor off");
    mon_watch_en = 1'b1;
    dbg_exc_en   = 1'b0;
    access(32'h1002, 2'd0, 1'b0, 1'b0, 2'd0, 4'h0);
    expect_miss("R9 debug off");
    dbg_exc_en   = 1'b1;

    // R10: link index beyond the context inputs
    cfg(3, 1'b1, mk_ctl(1'b1, 2'b11, 8'h01, 5'd0, 1'b1, 3'd5, 4'hF));
    access(32'h3000, 2'd0, 1'b0, 1'b0, 2'd0, 4'hF);
    expect_miss("R10 link out of range");

    // R4: upper select bits ignored in 4-aligned mode
    cfg(2, 1'b1, mk_ctl(1'b1, 2'b11, 8'hF0, 5'd0, 1'b0, 3'd0, 4'hF));
    access(32'h2004, 2'd2, 1'b0, 1'b0, 2'd0, 4'h0);
    expect_miss("R4 upper select ignored");
    // R3: same select from an 8-aligned value watches 0x2004..0x2007
    cfg(2, 1'b0, 32'h0000_2000);
    access(32'h2007, 2'd0, 1'b1, 1'b0, 2'd0, 4'h0);
    expect_hit("R3 high nibble run", 32'h2007, 1'b1, 2'd2);
    // R3: all-zero select disables
    cfg(2, 1'b1, mk_ctl(1'b1, 2'b11, 8'h00, 5'd0, 1'b0, 3'd0, 4'hF));
    access(32'h2000, 2'd3, 1'b0, 1'b0, 2'd0, 4'h0);
    expect_miss("R3 zero select");

    // R2: access type 00 disables
    cfg(0, 1'b1, mk_ctl(1'b1, 2'b00, 8'h0C, 5'd0, 1'b0, 3'd0, 4'hF));
    access(32'h1002, 2'd0, 1'b0, 1'b0, 2'd0, 4'h0);
    expect_miss("R2 type 00");

    // R6: reserved mask
    cfg(1, 1'b0, 32'h0002_3000);
    cfg(1, 1'b1, mk_ctl(1'b1, 2'b11, 8'hFF, 5'd2, 1'b0, 3'd0, 4'hF));
    access(32'h23000, 2'd0, 1'b1, 1'b0, 2'd0, 4'h0);
    expect_miss("R6 mask 2");
    cfg(1, 1'b1, mk_ctl(1'b1, 2'b11, 8'hFF, 5'd1, 1'b0, 3'd0, 4'hF));
    access(32'h23000, 2'd0, 1'b1, 1'b0, 2'd0, 4'h0);
    expect_miss("R6 mask 1");

    // R5: largest mask covers the upper 2 GB
    cfg(1, 1'b0, 32'h8000_0000);
    cfg(1, 1'b1, mk_ctl(1'b1, 2'b11, 8'h00, 5'd31, 1'b0, 3'd0, 4'hF));
    access(32'hFFFF_FFFC, 2'd2, 1'b0, 1'b0, 2'd2, 4'h0);
    expect_hit("R5 2GB top", 32'hFFFF_FFFC, 1'b0, 2'd1);
    access(32'h7FFF_FFFF, 2'd0, 1'b0, 1'b0, 2'd2, 4'h0);
    expect_miss("R5 2GB below");

    // R11: entries 0 and 1 both match, lowest wins
    cfg(0, 1'b0, 32'hFFFF_F000);
    cfg(0, 1'b1, mk_ctl(1'b1, 2'b11, 8'h00, 5'd12, 1'b0, 3'd0, 4'hF));
    access(32'hFFFF_FFFC, 2'd2, 1'b1, 1'b0, 2'd1, 4'h0);
    expect_hit("R11 priority", 32'hFFFF_FFFC, 1'b1, 2'd0);

    // R1: reset clears the configuration
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", {63'd0, wp_hit}, 64'd0);
    rst_n = 1'b1;
    access(32'hFFFF_FFFC, 2'd2, 1'b1, 1'b0, 2'd1, 4'h0);
    expect_miss("R1 entries cleared");

    summary();
    $finish;
  end

endmodule